// File: doc/BRIEF.md
# Chainable Gated PWM Counter

This block is an up-counting timer with a single pulse-width-modulated output. A period value sets how many counts make one cycle, and a compare value sets how many of those counts the output stays high. Each time the counter returns from its period value to zero it raises a one-clock update pulse on its trigger output.

The block can also act as a gated follower. It takes a small bus of trigger lines and a select field that picks one of them. In gated mode the counter steps only in clock cycles where the chosen line is high. Connect one stage's trigger output to a trigger line of the next stage and each stage then counts the update pulses of the stage before it. A chain of stages therefore divides the rate step by step: each stage's rate is the previous stage's update rate divided by its own period plus one.

A three-word write port loads the configuration. The current count is visible on an output port.

Top module: `cpt_timer`

## Requirements
- R1: After reset the count is 0 and both the PWM output and the trigger output are low. While enabled and free-running, the count rises by exactly one on every clock.
- R2: With period value P, the count runs 0..P and then returns to 0, so one cycle lasts P+1 steps. A free-running stage repeats every P+1 clocks.
- R3: The trigger output is high for exactly one clock, in the cycle in which the count has just returned to 0 from P. It is low in every other cycle.
- R4: The PWM output is high while the count is below the compare value C and low otherwise. A free-running stage with 1 <= C <= P is therefore high for C clocks of every P+1.
- R5: With C = 0 the PWM output stays low. With C > P it stays high.
- R6: When the enable bit (control bit 0) is 0, the count holds its value and no trigger pulse is produced.
- R7: When the gated bit (control bit 1) is 1, the count advances only in cycles where the selected trigger line is high, and it holds in every other cycle.
- R8: Control bits [2 +: SELW] hold an index, and that index picks which `trig_in` line gates the counter.
- R9: In a chain where each stage is gated by the previous stage's trigger output, stage k repeats every (P1+1)*...*(Pk+1) clocks. Its PWM output is high for Ck*(P1+1)*...*(Pk-1+1) clocks of that cycle.
- R10: A write with `cfg_we` high loads one word on the next clock edge. Address 0 loads the period, address 1 loads the compare value and address 2 loads the control word. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | WIDTH | Configuration write data |
| trig_in | input | NUM_TRIG | Candidate gate trigger lines |
| pwm_out | output | 1 | PWM output |
| trig_out | output | 1 | Update pulse, one clock wide |
| count_out | output | WIDTH | Current counter value |

## Verification
A configuration word takes effect at the clock edge that ends the write cycle. The count, the trigger pulse and the PWM level then change at the edges that follow. Every output is registered from the count, or derived combinationally from it, so all outputs are sampled on the falling edge, half a clock after the edge that updates them. Checks on period and duty never assume a starting phase. They wait for a rising PWM edge and then count falling-edge samples until the next rising edge. The gating check compares each sample of a follower's count against the previous sample plus the previous sample of its gate line. This matches the single register between the gate line and the count.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
   typedef enum logic [1:0] {
      ADDR_PERIOD  = 2'd0,
      ADDR_COMPARE = 2'd1,
      ADDR_CTRL    = 2'd2,
      ADDR_NONE    = 2'd3
   } cpt_addr_e;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_GATE_BIT = 1;
   localparam int CTRL_SEL_LSB  = 2;

   function automatic int sel_width(input int lines);
      return (lines > 1) ? $clog2(lines) : 1;
   endfunction
endpackage

// File: rtl/cpt_regs.sv
module cpt_regs
   import cpt_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int SELW  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_addr,
   input  logic [WIDTH-1:0] cfg_wdata,
   output logic [WIDTH-1:0] period,
   output logic [WIDTH-1:0] compare,
   output logic             enable,
   output logic             gated,
   output logic [SELW-1:0]  sel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period  <= '0;
         compare <= '0;
         enable  <= 1'b0;
         gated   <= 1'b0;
         sel     <= '0;
      end else if (cfg_we) begin
         case (cpt_addr_e'(cfg_addr))
            ADDR_PERIOD:  period  <= cfg_wdata;
            ADDR_COMPARE: compare <= cfg_wdata;
            ADDR_CTRL: begin
               enable <= cfg_wdata[CTRL_EN_BIT];
               gated  <= cfg_wdata[CTRL_GATE_BIT];
               sel    <= cfg_wdata[CTRL_SEL_LSB +: SELW];
            end
            default: ;
         endcase
      end
   end

   // R10: the unused address leaves every field untouched
   p_unused_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 2'd3) |=> ($stable(period) && $stable(compare)
                                        && $stable(enable) && $stable(sel)));
endmodule

// File: rtl/cpt_gate.sv
module cpt_gate #(
   parameter int NUM_TRIG = 4,
   parameter int SELW     = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_TRIG-1:0] trig_in,
   input  logic [SELW-1:0]     sel,
   input  logic                gated,
   input  logic                enable,
   output logic                tick
);
   logic line;

   generate
      if (NUM_TRIG == 1) begin : g_single
         assign line = trig_in[0];
      end else begin : g_mux
         always_comb begin
            line = 1'b0;
            for (int i = 0; i < NUM_TRIG; i++)
               if (sel == SELW'(i)) line = trig_in[i];
         end
      end
   endgenerate

   assign tick = enable & (~gated | line);

   p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !tick);
   p_free_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !gated) |-> tick);
endmodule

// File: rtl/cpt_counter.sv
module cpt_counter #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [WIDTH-1:0] period,
   output logic [WIDTH-1:0] cnt,
   output logic             upd
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         upd <= 1'b0;
      end else begin
         upd <= 1'b0;
         if (tick) begin
            if (cnt >= period) begin
               cnt <= '0;
               upd <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt < period) |=> (cnt == $past(cnt) + 1'b1));
   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt >= period) |=> (cnt == '0 && upd));
   p_pulse_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      upd |-> (cnt == '0));
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(cnt) && !upd));
endmodule

// File: rtl/cpt_compare.sv
module cpt_compare #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] cnt,
   input  logic [WIDTH-1:0] compare,
   output logic             pwm
);
   assign pwm = (cnt < compare);
endmodule

// File: rtl/cpt_timer.sv
module cpt_timer
   import cpt_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int NUM_TRIG = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [1:0]          cfg_addr,
   input  logic [WIDTH-1:0]    cfg_wdata,
   input  logic [NUM_TRIG-1:0] trig_in,
   output logic                pwm_out,
   output logic                trig_out,
   output logic [WIDTH-1:0]    count_out
);
   localparam int SELW = sel_width(NUM_TRIG);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("cpt_timer: WIDTH must be at least 2");
      end
      if (NUM_TRIG < 1) begin : g_bad_trig
         $error("cpt_timer: NUM_TRIG must be at least 1");
      end
      if (CTRL_SEL_LSB + SELW > WIDTH) begin : g_bad_ctrl
         $error("cpt_timer: control word does not fit in WIDTH");
      end
   endgenerate

   logic [WIDTH-1:0] period, compare, cnt;
   logic             enable, gated, tick, upd, pwm;
   logic [SELW-1:0]  sel;

   cpt_regs #(.WIDTH(WIDTH), .SELW(SELW)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .period(period), .compare(compare),
      .enable(enable), .gated(gated), .sel(sel)
   );

   cpt_gate #(.NUM_TRIG(NUM_TRIG), .SELW(SELW)) u_gate (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sel(sel),
      .gated(gated), .enable(enable), .tick(tick)
   );

   cpt_counter #(.WIDTH(WIDTH)) u_counter (
      .clk(clk), .rst_n(rst_n), .tick(tick), .period(period),
      .cnt(cnt), .upd(upd)
   );

   cpt_compare #(.WIDTH(WIDTH)) u_compare (
      .cnt(cnt), .compare(compare), .pwm(pwm)
   );

   assign pwm_out   = pwm;
   assign trig_out  = upd;
   assign count_out = cnt;

   p_zero_compare_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (compare == '0) |-> !pwm_out);
   p_no_pulse_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !$past(enable)) |-> !trig_out);
endmodule

// File: tb/cpt_timer_test.sv
module cpt_timer_test;
   localparam int W = 8;
   localparam int NT = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [2:0]   we = '0;
   logic [1:0]   addr = '0;
   logic [W-1:0] wdata = '0;
   logic [2:0]   pwm_w, trg_w;
   logic [W-1:0] cnt_w [3];

   int n_chk = 0;
   int n_bad = 0;

   cpt_timer #(.WIDTH(W), .NUM_TRIG(NT)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(we[0]), .cfg_addr(addr),
      .cfg_wdata(wdata), .trig_in(4'b0000), .pwm_out(pwm_w[0]),
      .trig_out(trg_w[0]), .count_out(cnt_w[0]));
   cpt_timer #(.WIDTH(W), .NUM_TRIG(NT)) uut_s2 (
      .clk(clk), .rst_n(rst_n), .cfg_we(we[1]), .cfg_addr(addr),
      .cfg_wdata(wdata), .trig_in({2'b00, trg_w[0], 1'b0}),
      .pwm_out(pwm_w[1]), .trig_out(trg_w[1]), .count_out(cnt_w[1]));
   cpt_timer #(.WIDTH(W), .NUM_TRIG(NT)) uut_s3 (
      .clk(clk), .rst_n(rst_n), .cfg_we(we[2]), .cfg_addr(addr),
      .cfg_wdata(wdata), .trig_in({1'b0, trg_w[1], trg_w[0], 1'b0}),
      .pwm_out(pwm_w[2]), .trig_out(trg_w[2]), .count_out(cnt_w[2]));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int s, input logic [1:0] a, input int d);
      @(negedge clk);
      we[s] = 1'b1; addr = a; wdata = W'(d);
      @(negedge clk);
      we = '0;
   endtask

   task automatic meas(input int s, output int per, output int hi);
      logic prev;
      int t;
      bit fell;
      per = -1; hi = -1;
      prev = pwm_w[s];
      t = 0;
      @(negedge clk);
      while (!(!prev && pwm_w[s]) && t < 20000) begin
         prev = pwm_w[s]; t++; @(negedge clk);
      end
      if (t >= 20000) return;
      per = 0; hi = 0; fell = 0;
      do begin
         if (!fell && pwm_w[s]) hi++; else fell = 1;
         per++;
         @(negedge clk);
      end while (!(fell && pwm_w[s]) && per < 20000);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      int per, hi, bad, pulses;
      logic [W-1:0] pc;
      logic pt;
      #23 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      for (int s = 0; s < 3; s++)
         chk(cnt_w[s] == 0 && !pwm_w[s] && !trg_w[s], "R1 reset",
             int'(cnt_w[s]) + int'(pwm_w[s]) + int'(trg_w[s]), 0);

      // stage 1 free-running, P=7 C=2
      wr(0, 2'd0, 7); wr(0, 2'd1, 2); wr(0, 2'd2, 1);
      repeat (3) @(negedge clk);
      bad = 0; pulses = 0;
      pc = cnt_w[0];
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (cnt_w[0] != W'((int'(pc) + 1) % 8)) bad++;
         if (trg_w[0] != (cnt_w[0] == 0)) bad++;
         if (trg_w[0]) pulses++;
         pc = cnt_w[0];
      end
      chk(bad == 0, "R1 step / R3 pulse placement", bad, 0);
      chk(pulses == 5, "R2 wrap count in 40 clocks", pulses, 5);

      // R2/R4 sweep over period and compare
      for (int p = 3; p <= 7; p += 2) begin
         for (int c = 1; c <= p; c++) begin
            wr(0, 2'd0, p); wr(0, 2'd1, c);
            meas(0, per, hi);
            chk(per == p + 1, "R2 period", per, p + 1);
            chk(hi == c, "R4 high time", hi, c);
         end
         // R5: constant levels
         wr(0, 2'd1, 0);
         bad = 0;
         for (int i = 0; i < 3 * (p + 1); i++) begin
            @(negedge clk); if (pwm_w[0]) bad++;
         end
         chk(bad == 0, "R5 compare zero low", bad, 0);
         wr(0, 2'd1, p + 2);
         bad = 0;
         for (int i = 0; i < 3 * (p + 1); i++) begin
            @(negedge clk); if (!pwm_w[0]) bad++;
         end
         chk(bad == 0, "R5 compare above period high", bad, 0);
      end

      // chain: stage1 P=7 C=2, stage2 P=3 C=1 on line 1, stage3 P=3 C=1 on line 2
      wr(0, 2'd0, 7); wr(0, 2'd1, 2);
      wr(1, 2'd0, 3); wr(1, 2'd1, 1); wr(1, 2'd2, 1 | 2 | (1 << 2));
      wr(2, 2'd0, 3); wr(2, 2'd1, 1); wr(2, 2'd2, 1 | 2 | (2 << 2));
      meas(1, per, hi);
      chk(per == 32, "R9 stage2 period", per, 32);
      chk(hi == 8, "R9 stage2 high time", hi, 8);
      meas(2, per, hi);
      chk(per == 128, "R9 stage3 period", per, 128);
      chk(hi == 32, "R9 stage3 high time", hi, 32);

      // R7: gated follower advances only after a gate-high cycle
      bad = 0;
      @(negedge clk);
      pc = cnt_w[1]; pt = trg_w[0];
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (cnt_w[1] != (pt ? W'((int'(pc) + 1) % 4) : pc)) bad++;
         pc = cnt_w[1]; pt = trg_w[0];
      end
      chk(bad == 0, "R7 gated stepping", bad, 0);

      // R8: stage3 reselected to line 1 (stage1 updates)
      wr(2, 2'd2, 1 | 2 | (1 << 2));
      meas(2, per, hi);
      chk(per == 32, "R8 select line 1 period", per, 32);
      chk(hi == 8, "R8 select line 1 high time", hi, 8);

      // R6: disable stage1; it and its follower freeze
      wr(0, 2'd2, 0);
      @(negedge clk);
      pc = cnt_w[0];
      bad = 0; pulses = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (cnt_w[0] != pc) bad++;
         if (trg_w[0]) pulses++;
      end
      chk(bad == 0, "R6 count holds when disabled", bad, 0);
      chk(pulses == 0, "R6 no pulses when disabled", pulses, 0);

      // R10: write to address 3 is ignored, then re-enable
      wr(0, 2'd3, 8'hFF);
      wr(0, 2'd2, 1);
      meas(0, per, hi);
      chk(per == 8, "R10 period kept after unused write", per, 8);
      chk(hi == 2, "R10 compare kept after unused write", hi, 2);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule